// File: doc/BRIEF.md
# Dual-Mode Serial Baud Rate Generator

This block derives the timing for a serial transmitter and receiver from the system clock. A reload value N is written through a low register and a high register. A free-running down-counter expires once every N + 1 system clocks and raises a one-cycle tick each time it expires. A phase divider counts these ticks and raises a one-cycle bit strobe on every M-th tick. The period of one serial bit is therefore M × (N + 1) system clocks.

Three mode inputs set the counter width and the multiplier M. The narrow mode uses only the low register. The wide mode joins the two registers into one 16-bit reload value. In asynchronous operation M is 64, 16 or 4, depending on two mode bits taken together. In synchronous master operation M is always 4, and the block also drives a serial clock that is low for the first half of each bit period and high for the second half. Writing either period register restarts the count at once, so a new rate takes effect without waiting for the old period to finish.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst_n` is low, `os_tick`, `bit_strobe` and `sync_clk_out` are 0. Reset clears both period registers to zero. With no writes after reset, enabling the block in asynchronous narrow slow mode gives a tick on every clock and a strobe on every 64th clock.
- R2: When `enable` is low, from the first clock edge after it is sampled low, `os_tick`, `bit_strobe` and `sync_clk_out` stay 0.
- R3: The enable input is registered. Number the cycles 1, 2, 3 and so on, starting with the first cycle after the edge that samples `enable` high. `os_tick` is 1 exactly in the cycles whose number is a multiple of N + 1. When `wide_mode` = 0, N equals the low register, and the high register has no effect.
- R4: When `wide_mode` = 1, N = {high register, low register}, with the high register as the upper byte.
- R5: `bit_strobe` is 1 exactly in the cycles whose number is a multiple of M × (N + 1). In asynchronous mode (`sync_mode` = 0), M depends on `wide_mode` and `fast_mode`. M = 64 when both are 0. M = 16 when exactly one of them is 1. M = 4 when both are 1.
- R6: When `sync_mode` = 1, M = 4 whatever the value of `fast_mode`.
- R7: A write pulse on `lo_we` or `hi_we` restarts both the count and the tick phase. Numbering the cycles from the edge that takes the write, the patterns of R3 and R5 start again with the new N.
- R8: When `sync_mode` = 1 and the block is enabled, `sync_clk_out` is 1 exactly when floor((c−1)/(N+1)) mod 4 is 2 or 3, where c is the cycle number defined in R3. When `sync_mode` = 0, `sync_clk_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Generator run enable |
| sync_mode | input | 1 | 1 selects synchronous master timing |
| wide_mode | input | 1 | 1 selects the 16-bit reload value |
| fast_mode | input | 1 | High-speed divisor select, used only in asynchronous mode |
| lo_we | input | 1 | Write strobe for the low period register |
| lo_wdata | input | 8 | Data for the low period register |
| hi_we | input | 1 | Write strobe for the high period register |
| hi_wdata | input | 8 | Data for the high period register |
| os_tick | output | 1 | One-cycle pulse each time the counter expires |
| bit_strobe | output | 1 | One-cycle pulse once per bit period |
| sync_clk_out | output | 1 | Serial clock driven in synchronous mode |

## Verification
Every result is due at a cycle that follows from the requirements. A change on `enable` or a period write is taken at one clock edge. The output pattern then starts in the cycle right after that edge. A tick is due N + 1 cycles later, and a strobe M × (N + 1) cycles later. The bench drives all inputs and samples all outputs on the falling clock edge. It numbers the cycles from the edge that took the stimulus, and compares each of the three outputs in every cycle against the formula for that cycle number. This checks the exact cycle of each result, not just an average rate.

// File: rtl/baud_pkg.sv
package baud_pkg;

  localparam int unsigned MULT_MAX = 64;
  localparam int unsigned PH_W     = $clog2(MULT_MAX);

  typedef struct packed {
    logic sync;
    logic wide;
    logic fast;
  } brg_mode_t;

  // Ticks per bit period for a given mode
  function automatic logic [PH_W:0] ticks_per_bit(input brg_mode_t m);
    logic [PH_W:0] r;
    if (m.sync) begin
      r = (PH_W+1)'(4);
    end else begin
      unique case ({m.wide, m.fast})
        2'b00:   r = (PH_W+1)'(64);
        2'b11:   r = (PH_W+1)'(4);
        default: r = (PH_W+1)'(16);
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/baud_period_regs.sv
module baud_period_regs #(
  parameter int unsigned LO_W = 8,
  parameter int unsigned HI_W = 8,
  localparam int unsigned CNT_W = LO_W + HI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide_mode,
  input  logic             lo_we,
  input  logic [LO_W-1:0]  lo_wdata,
  input  logic             hi_we,
  input  logic [HI_W-1:0]  hi_wdata,
  output logic             wr_evt,
  output logic [CNT_W-1:0] period_q,
  output logic [CNT_W-1:0] period_nx
);

  logic [LO_W-1:0] lo_q, lo_nx;
  logic [HI_W-1:0] hi_q, hi_nx;

  function automatic logic [CNT_W-1:0] eff_period(input logic w,
                                                  input logic [HI_W-1:0] h,
                                                  input logic [LO_W-1:0] l);
    return w ? {h, l} : {{HI_W{1'b0}}, l};
  endfunction

  assign lo_nx  = lo_we ? lo_wdata : lo_q;
  assign hi_nx  = hi_we ? hi_wdata : hi_q;
  assign wr_evt = lo_we | hi_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_nx;
      hi_q <= hi_nx;
    end
  end

  assign period_q  = eff_period(wide_mode, hi_q, lo_q);
  assign period_nx = eff_period(wide_mode, hi_nx, lo_nx);

  assert_narrow_ignores_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_mode |-> (period_q[CNT_W-1:LO_W] == '0));

endmodule

// File: rtl/baud_tick_counter.sv
module baud_tick_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_q,
  input  logic             wr_evt,
  input  logic [CNT_W-1:0] period_q,
  input  logic [CNT_W-1:0] period_nx,
  output logic             tick,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (wr_evt) begin
      cnt <= period_nx;
    end else if (!en_q || cnt == '0) begin
      cnt <= period_q;
    end else begin
      cnt <= cnt - ONE;
    end
  end

  assign tick = en_q && (cnt == '0);

  assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !wr_evt && cnt != '0) |=> (cnt == $past(cnt) - ONE));

endmodule

// File: rtl/baud_phase_div.sv
module baud_phase_div
  import baud_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_q,
  input  logic            wr_evt,
  input  logic            tick,
  input  brg_mode_t       mode,
  output logic            strobe,
  output logic [PH_W-1:0] ph
);

  logic [PH_W:0] lim_m1;
  logic          at_last;

  assign lim_m1  = ticks_per_bit(mode) - (PH_W+1)'(1);
  assign at_last = ({1'b0, ph} >= lim_m1);
  assign strobe  = tick && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= '0;
    end else if (!en_q || wr_evt) begin
      ph <= '0;
    end else if (tick) begin
      ph <= at_last ? '0 : ph + PH_W'(1);
    end
  end

  assert_phase_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !wr_evt && !tick) |=> $stable(ph));

  assert_phase_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !wr_evt && strobe) |=> (ph == '0));

  assert_phase_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !wr_evt && tick && !strobe) |=> (ph == $past(ph) + PH_W'(1)));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int unsigned LO_W = 8,
  parameter int unsigned HI_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            sync_mode,
  input  logic            wide_mode,
  input  logic            fast_mode,
  input  logic            lo_we,
  input  logic [LO_W-1:0] lo_wdata,
  input  logic            hi_we,
  input  logic [HI_W-1:0] hi_wdata,
  output logic            os_tick,
  output logic            bit_strobe,
  output logic            sync_clk_out
);

  localparam int unsigned CNT_W = LO_W + HI_W;

  logic             en_q;
  logic             wr_evt;
  logic             tick_evt;
  logic             strobe_evt;
  logic [CNT_W-1:0] period_q, period_nx, cnt;
  logic [PH_W-1:0]  ph;
  brg_mode_t        mode;

  assign mode = '{sync: sync_mode, wide: wide_mode, fast: fast_mode};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= enable;
  end

  baud_period_regs #(.LO_W(LO_W), .HI_W(HI_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
    .lo_we(lo_we), .lo_wdata(lo_wdata), .hi_we(hi_we), .hi_wdata(hi_wdata),
    .wr_evt(wr_evt), .period_q(period_q), .period_nx(period_nx)
  );

  baud_tick_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .wr_evt(wr_evt),
    .period_q(period_q), .period_nx(period_nx), .tick(tick_evt), .cnt(cnt)
  );

  baud_phase_div phase_i (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .wr_evt(wr_evt), .tick(tick_evt),
    .mode(mode), .strobe(strobe_evt), .ph(ph)
  );

  assign os_tick      = tick_evt;
  assign bit_strobe   = strobe_evt;
  assign sync_clk_out = sync_mode && en_q && ph[1];

  assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (!os_tick && !bit_strobe && !sync_clk_out));

  assert_write_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> (ph == '0) && (!$stable(wide_mode) || cnt == period_q));

  assert_sync_four_ticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && $past(sync_mode) && bit_strobe) |-> (ph == PH_W'(3)));

endmodule

// File: tb/baud_tick_gen_tb_top.sv
module baud_tick_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       sync_mode = 1'b0, wide_mode = 1'b0, fast_mode = 1'b0;
  logic       lo_we = 1'b0, hi_we = 1'b0;
  logic [7:0] lo_wdata = '0, hi_wdata = '0;
  logic       os_tick, bit_strobe, sync_clk_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  baud_tick_gen dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sync_mode(sync_mode),
    .wide_mode(wide_mode), .fast_mode(fast_mode), .lo_we(lo_we),
    .lo_wdata(lo_wdata), .hi_we(hi_we), .hi_wdata(hi_wdata),
    .os_tick(os_tick), .bit_strobe(bit_strobe), .sync_clk_out(sync_clk_out)
  );

  function automatic int mult_of(bit s, bit w, bit f);
    if (s) return 4;
    if (w && f) return 4;
    if (w || f) return 16;
    return 64;
  endfunction

  task automatic check_bit(string req, string what, int cyc, bit act, bit exp,
                           inout int mism);
    if (act !== exp) begin
      if (mism == 0)
        $display("FAIL %s %s at cycle %0d: actual=%0b expected=%0b",
                 req, what, cyc, act, exp);
      mism++;
    end
  endtask

  task automatic tally(int mism);
    total++;
    if (mism != 0) bad++;
  endtask

  task automatic configure(bit s, bit w, bit f, logic [7:0] hi, logic [7:0] lo);
    @(negedge clk);
    sync_mode = s; wide_mode = w; fast_mode = f;
    hi_we = 1'b1; hi_wdata = hi; lo_we = 1'b1; lo_wdata = lo;
    @(negedge clk);
    hi_we = 1'b0; lo_we = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Samples cycles 1..k after the edge that took the stimulus
  task automatic sample_run(string req, int n, int m, bit s, int k);
    int mt = 0, ms = 0, mc = 0;
    for (int c = 1; c <= k; c++) begin
      @(negedge clk);
      if (lo_we || hi_we) begin lo_we = 1'b0; hi_we = 1'b0; end
      check_bit(req, "os_tick", c, os_tick, (c % (n + 1)) == 0, mt);
      check_bit(req, "bit_strobe", c, bit_strobe, (c % ((n + 1) * m)) == 0, ms);
      check_bit(req, "sync_clk_out", c, sync_clk_out,
                s && ((((c - 1) / (n + 1)) % 4) >= 2), mc);
    end
    tally(mt); tally(ms); tally(mc);
  endtask

  task automatic run_enabled(string req, int n, int m, bit s, int k);
    @(negedge clk);
    enable = 1'b1;
    sample_run(req, n, m, s, k);
    enable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    int mz = 0;
    enable = 1'b1; sync_mode = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check_bit("R1", "outputs in reset", i, os_tick | bit_strobe | sync_clk_out, 1'b0, mz);
    end
    tally(mz);
    enable = 1'b0; sync_mode = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_enabled("R1", 0, 64, 1'b0, 130);
  endtask

  task automatic t_narrow;
    configure(1'b0, 1'b0, 1'b0, 8'h37, 8'd5);
    run_enabled("R3", 5, mult_of(0, 0, 0), 1'b0, 400);
  endtask

  task automatic t_wide;
    configure(1'b0, 1'b1, 1'b0, 8'd1, 8'd2);
    run_enabled("R4", 258, mult_of(0, 1, 0), 1'b0, 4200);
  endtask

  task automatic t_mults;
    configure(1'b0, 1'b0, 1'b1, 8'd0, 8'd2);
    run_enabled("R5", 2, mult_of(0, 0, 1), 1'b0, 100);
    configure(1'b0, 1'b1, 1'b1, 8'd0, 8'd3);
    run_enabled("R5", 3, mult_of(0, 1, 1), 1'b0, 40);
  endtask

  task automatic t_sync;
    configure(1'b1, 1'b0, 1'b0, 8'd0, 8'd2);
    run_enabled("R6", 2, mult_of(1, 0, 0), 1'b1, 40);
    configure(1'b1, 1'b1, 1'b1, 8'd0, 8'd1);
    run_enabled("R8", 1, mult_of(1, 1, 1), 1'b1, 30);
  endtask

  task automatic t_disabled;
    int mz = 0;
    configure(1'b1, 1'b0, 1'b0, 8'd0, 8'd0);
    @(negedge clk);
    enable = 1'b1;
    repeat (10) @(negedge clk);
    enable = 1'b0;
    for (int c = 1; c <= 20; c++) begin
      @(negedge clk);
      check_bit("R2", "outputs while disabled", c,
                os_tick | bit_strobe | sync_clk_out, 1'b0, mz);
    end
    tally(mz);
  endtask

  task automatic t_restart;
    configure(1'b0, 1'b1, 1'b1, 8'd0, 8'd9);
    @(negedge clk);
    enable = 1'b1;
    sample_run("R3", 9, 4, 1'b0, 13);
    lo_wdata = 8'd3; lo_we = 1'b1;
    sample_run("R7", 3, 4, 1'b0, 40);
    enable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_narrow();
    t_wide();
    t_mults();
    t_sync();
    t_disabled();
    t_restart();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule